// File: doc/BRIEF.md
# FIR Multiply-Accumulate Datapath with Coefficient Rounding

This block is the arithmetic core of a direct-form FIR filter. Each cycle it can take one 16-bit signed data sample and one 16-bit signed coefficient, both fractions with a single sign bit ahead of the binary point. The caller supplies them, tap by tap, from its own coefficient store and delay line. The coefficient is first narrowed to 12 bits by rounding towards zero. It is then multiplied by the sample at full precision. The product drops its four lowest bits and is widened with its sign into a 32-bit accumulator.

Two flags go with every valid pair. `tapFirst` makes the accumulator start a new output sample by loading the product rather than adding it, so no idle cycle is needed between samples. `tapLast` marks the final tap. Once that tap's product has been added in, the block captures the full 32-bit sum and a 16-bit mid-word slice. The slice is meant to drive the data input of a second filter stage. A one-cycle strobe announces the captured result. The accumulator wraps modulo 2^32 and does not saturate.

Top module: `fir_mac_engine`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `resValid` is 0 and `resData` and `cascData` are all zeros.
- R2: A coefficient with bit 15 equal to 0 is reduced to its bits 15..4, with bits 3..0 discarded. A coefficient whose bits 3..0 are zero is therefore used unchanged.
- R3: A coefficient with bit 15 equal to 1 is reduced to bits 15..4 plus 1 when any of bits 3..0 is set, which rounds it towards zero.
- R4: The 16x12 product is exact in 28 bits. Data 0x8000 times coefficient 0x8000 gives an accumulator term of 0x00400000.
- R5: The accumulator term is the 28-bit product shifted right by 4 with the sign kept (floor), then sign-extended to 32 bits. Data 0xFFFF times coefficient 0x0010 gives 0xFFFFFFFF.
- R6: A valid tap with `tapFirst`=1 loads its term into the accumulator. A valid tap with `tapFirst`=0 adds its term to the running sum.
- R7: A valid tap with `tapLast`=1 presented before clock edge k makes `resValid` high for exactly the cycle after edge k+1. In that cycle `resData` holds the sum including that tap. `resValid` is 0 in every other cycle.
- R8: `cascData` equals bits 23..8 of the result captured with it.
- R9: Cycles with `tapValid`=0 change neither the accumulator nor the outputs, whatever the other inputs carry.
- R10: The sum wraps in two's complement on overflow. 520 terms of 0x00400000 give 0x82000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tapValid | input | 1 | Data/coefficient pair is valid this cycle |
| tapFirst | input | 1 | Pair is the first tap of an output sample |
| tapLast | input | 1 | Pair is the last tap of an output sample |
| tapData | input | 16 | Signed data sample |
| tapCoef | input | 16 | Signed coefficient before rounding |
| resValid | output | 1 | One-cycle strobe: a finished sum is on the outputs |
| resData | output | 32 | Finished 32-bit sum |
| cascData | output | 16 | Bits 23..8 of the sum, for a cascaded stage |

## Verification
A finished sum reaches the ports two rising edges after its last tap is presented. The first edge registers the product and the second adds it in and captures the result. The bench drives inputs on falling edges. It records each expected sum in a queue with the cycle number at which it is due. At every falling edge it checks either that the due sum and slice are present with `resValid` high, or that `resValid` is low. Sweeps cover every coefficient value and a strided range of data values against arithmetic computed in the bench. Tap sequences of random length are interleaved with invalid cycles that carry junk, and a long run of maximum terms forces a wrap.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;
  typedef struct packed {
    logic stageEn;     // register a new product
    logic accLoad;     // accumulator takes the product alone
    logic accAdd;      // accumulator adds the product
    logic resCapture;  // capture the finished sum
  } macStrobes_t;
endpackage

// File: rtl/fir_mac_ctrl.sv
module fir_mac_ctrl
  import fir_mac_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tapValid,
  input  logic        tapFirst,
  input  logic        tapLast,
  output macStrobes_t strobes,
  output logic        resValid
);
  logic s1Valid, s1First, s1Last;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid  <= 1'b0;
      s1First  <= 1'b0;
      s1Last   <= 1'b0;
      resValid <= 1'b0;
    end else begin
      s1Valid  <= tapValid;
      if (tapValid) begin
        s1First <= tapFirst;
        s1Last  <= tapLast;
      end
      resValid <= s1Valid & s1Last;
    end
  end

  always_comb begin
    strobes.stageEn    = tapValid;
    strobes.accLoad    = s1Valid & s1First;
    strobes.accAdd     = s1Valid & ~s1First;
    strobes.resCapture = s1Valid & s1Last;
  end

  // R7: a result strobe needs a valid last tap two edges earlier
  a_r7_result_after_last: assert property (@(posedge clk) disable iff (rst)
    resValid |-> ($past(tapValid, 2) && $past(tapLast, 2)));

  // R6: a load happens only for a tap that was flagged first
  a_r6_load_from_first: assert property (@(posedge clk) disable iff (rst)
    strobes.accLoad |-> $past(tapValid && tapFirst));
endmodule

// File: rtl/fir_mac_datapath.sv
module fir_mac_datapath
  import fir_mac_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_KEEP = 12,
  parameter int PROD_DROP = 4,
  parameter int ACC_W     = 32,
  parameter int CASC_LSB  = 8,
  parameter int CASC_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  macStrobes_t       strobes,
  input  logic [DATA_W-1:0] tapData,
  input  logic [COEF_W-1:0] tapCoef,
  output logic [ACC_W-1:0]  resData,
  output logic [CASC_W-1:0] cascData
);
  localparam int COEF_DROP = COEF_W - COEF_KEEP;
  localparam int PROD_W    = DATA_W + COEF_KEEP;
  localparam int TRUNC_W   = PROD_W - PROD_DROP;

  // Stage 1: coefficient rounding towards zero
  logic [COEF_KEEP-1:0] coefRnd;
  generate
    if (COEF_DROP > 0) begin : g_round
      logic lowAny;
      assign lowAny  = |tapCoef[COEF_DROP-1:0];
      assign coefRnd = tapCoef[COEF_W-1:COEF_DROP]
                     + {{(COEF_KEEP-1){1'b0}}, tapCoef[COEF_W-1] & lowAny};
    end else begin : g_pass
      assign coefRnd = tapCoef;
    end
  endgenerate

  // Stage 1: full-precision signed product
  logic [PROD_W-1:0] dataExt, coefExt, prodFull, prodQ;
  assign dataExt  = {{COEF_KEEP{tapData[DATA_W-1]}}, tapData};
  assign coefExt  = {{DATA_W{coefRnd[COEF_KEEP-1]}}, coefRnd};
  assign prodFull = dataExt * coefExt;

  always_ff @(posedge clk) begin
    if (rst)                 prodQ <= '0;
    else if (strobes.stageEn) prodQ <= prodFull;
  end

  // Stage 2: truncate, sign-extend, accumulate
  logic signed [ACC_W-1:0] prodExt;
  logic [ACC_W-1:0] accQ, accNext;
  assign prodExt = ACC_W'($signed(prodQ) >>> PROD_DROP);
  assign accNext = strobes.accLoad ? prodExt : (accQ + prodExt);

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ     <= '0;
      resData  <= '0;
      cascData <= '0;
    end else begin
      if (strobes.accLoad || strobes.accAdd) accQ <= accNext;
      if (strobes.resCapture) begin
        resData  <= accNext;
        cascData <= accNext[CASC_LSB+CASC_W-1:CASC_LSB];
      end
    end
  end

  // Rounding check in plain integers
  int coefFull, coefBack;
  always_comb begin
    coefFull = int'($signed(tapCoef));
    coefBack = int'($signed(coefRnd)) * (2 ** COEF_DROP);
  end

  // R2 and R3: rounded value never exceeds the original in magnitude, and is within one step of it
  a_r3_round_toward_zero: assert property (@(posedge clk) disable iff (rst)
    strobes.stageEn |-> ((coefFull >= 0)
      ? ((coefFull - coefBack) >= 0 && (coefFull - coefBack) < (2 ** COEF_DROP))
      : ((coefBack - coefFull) >= 0 && (coefBack - coefFull) < (2 ** COEF_DROP))));

  // R5: a freshly loaded sum fits in the truncated product width
  a_r5_load_fits: assert property (@(posedge clk) disable iff (rst)
    strobes.accLoad |=> ((&accQ[ACC_W-1:TRUNC_W-1]) || (~|accQ[ACC_W-1:TRUNC_W-1])));

  // R9: without a strobe the accumulator holds
  a_r9_acc_holds: assert property (@(posedge clk) disable iff (rst)
    !(strobes.accLoad || strobes.accAdd) |=> $stable(accQ));
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
  import fir_mac_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_KEEP = 12,
  parameter int PROD_DROP = 4,
  parameter int ACC_W     = 32,
  parameter int CASC_LSB  = 8,
  parameter int CASC_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tapValid,
  input  logic              tapFirst,
  input  logic              tapLast,
  input  logic [DATA_W-1:0] tapData,
  input  logic [COEF_W-1:0] tapCoef,
  output logic              resValid,
  output logic [ACC_W-1:0]  resData,
  output logic [CASC_W-1:0] cascData
);
  macStrobes_t strobes;

  fir_mac_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .tapValid(tapValid), .tapFirst(tapFirst), .tapLast(tapLast),
    .strobes(strobes), .resValid(resValid)
  );

  fir_mac_datapath #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_KEEP(COEF_KEEP),
    .PROD_DROP(PROD_DROP), .ACC_W(ACC_W),
    .CASC_LSB(CASC_LSB), .CASC_W(CASC_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .tapData(tapData), .tapCoef(tapCoef),
    .resData(resData), .cascData(cascData)
  );

  // R8: the slice matches the sum it was captured with
  a_r8_cascade_slice: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (cascData == resData[CASC_LSB+CASC_W-1:CASC_LSB]));
endmodule

// File: tb/tb_fir_mac_engine.sv
module tb_fir_mac_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tapValid = 1'b0, tapFirst = 1'b0, tapLast = 1'b0;
  logic [15:0] tapData = '0, tapCoef = '0;
  logic        resValid;
  logic [31:0] resData;
  logic [15:0] cascData;

  always #2 clk = ~clk;  // 250 MHz

  fir_mac_engine dut (
    .clk(clk), .rst(rst), .tapValid(tapValid), .tapFirst(tapFirst),
    .tapLast(tapLast), .tapData(tapData), .tapCoef(tapCoef),
    .resValid(resValid), .resData(resData), .cascData(cascData)
  );

  int checks = 0, errors = 0;
  int cycNum = 0;
  bit monOn = 1'b0;
  int          dueQ[$];
  logic [31:0] valQ[$];
  string       tagQ[$];
  logic [31:0] rnd = 32'h1ACE_B00C;

  always @(posedge clk) cycNum <= cycNum + 1;

  function automatic logic [31:0] nextRnd(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [31:0] term(input logic [15:0] d, input logic [15:0] c);
    longint cr, p;
    cr = longint'($signed(c)) >>> 4;
    if (c[15] && (c[3:0] != 4'd0)) cr = cr + 1;
    p = longint'($signed(d)) * cr;
    return 32'(p >>> 4);
  endfunction

  task automatic drive(input logic v, input logic f, input logic l,
                       input logic [15:0] d, input logic [15:0] c);
    @(negedge clk);
    tapValid = v; tapFirst = f; tapLast = l; tapData = d; tapCoef = c;
  endtask

  task automatic expect_at(input logic [31:0] v, input string tag);
    dueQ.push_back(cycNum + 2);
    valQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  // Monitor: every falling edge, either a due result or no strobe
  always @(negedge clk) begin
    if (monOn) begin
      checks++;
      if (dueQ.size() > 0 && dueQ[0] == cycNum) begin
        logic [31:0] ev;
        string tg;
        ev = valQ.pop_front();
        tg = tagQ.pop_front();
        void'(dueQ.pop_front());
        if (!resValid || resData !== ev || cascData !== ev[23:8]) begin
          errors++;
          $display("FAIL %s/R7/R8 cyc %0d: valid=%0b data=%h casc=%h expected data=%h casc=%h",
                   tg, cycNum, resValid, resData, cascData, ev, ev[23:8]);
        end
      end else if (resValid !== 1'b0) begin
        errors++;
        $display("FAIL R7 cyc %0d: unexpected resValid=%0b expected 0", cycNum, resValid);
      end
    end
  end

  initial begin
    repeat (199000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] sum;
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (resValid !== 1'b0 || resData !== 32'd0 || cascData !== 16'd0) begin
      errors++;
      $display("FAIL R1 in reset: valid=%0b data=%h casc=%h expected 0/0/0", resValid, resData, cascData);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (resValid !== 1'b0 || resData !== 32'd0 || cascData !== 16'd0) begin
      errors++;
      $display("FAIL R1 after reset: valid=%0b data=%h casc=%h expected 0/0/0", resValid, resData, cascData);
    end
    monOn = 1'b1;

    // R4 and R5 corners
    drive(1, 1, 1, 16'h8000, 16'h8000); expect_at(32'h0040_0000, "R4");
    drive(1, 1, 1, 16'hFFFF, 16'h0010); expect_at(32'hFFFF_FFFF, "R5");
    drive(1, 1, 1, 16'h0001, 16'h0010); expect_at(32'h0000_0000, "R5");

    // R2/R3: every coefficient, single-tap samples back to back
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] c;
      c = 16'(i);
      drive(1, 1, 1, 16'h4000, c);
      expect_at(term(16'h4000, c), c[15] ? "R3" : "R2");
    end

    // R4/R5: strided data sweep against a few coefficients
    for (int i = 0; i < 65536; i += 7) begin
      logic [15:0] d;
      d = 16'(i);
      drive(1, 1, 1, d, 16'h8000); expect_at(term(d, 16'h8000), "R4");
      drive(1, 1, 1, d, 16'h7FF3); expect_at(term(d, 16'h7FF3), "R5");
      drive(1, 1, 1, d, 16'hFFF1); expect_at(term(d, 16'hFFF1), "R3");
    end

    // R6/R9: multi-tap samples with junk-carrying idle cycles between taps
    for (int s = 0; s < 400; s++) begin
      int len;
      rnd = nextRnd(rnd);
      len = 1 + int'(rnd[2:0]);
      sum = '0;
      for (int k = 0; k < len; k++) begin
        logic [15:0] d, c;
        rnd = nextRnd(rnd); d = rnd[15:0]; c = rnd[31:16];
        if (rnd[5] && rnd[9]) begin
          rnd = nextRnd(rnd);
          drive(0, rnd[0], rnd[1], rnd[15:0], rnd[31:16]);  // R9: ignored
        end
        sum = (k == 0) ? term(d, c) : sum + term(d, c);
        drive(1, k == 0, k == len - 1, d, c);
        if (k == len - 1) expect_at(sum, "R6");
      end
    end

    // R10: overflow wraps
    sum = '0;
    for (int k = 0; k < 520; k++) begin
      drive(1, k == 0, k == 519, 16'h8000, 16'h8000);
      sum = sum + 32'h0040_0000;
    end
    expect_at(sum, "R10");
    checks++;
    if (sum !== 32'h8200_0000) begin
      errors++;
      $display("FAIL R10 bench sum: got %h expected 82000000", sum);
    end

    drive(0, 0, 0, 16'h0, 16'h0);
    repeat (6) @(negedge clk);
    checks++;
    if (dueQ.size() != 0) begin
      errors++;
      $display("FAIL R7: %0d results missing, expected 0", dueQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule